// File: doc/BRIEF.md
# Byte-Serial Command Word Decoder

This block sits on a byte-wide communication port and packs the incoming bytes into 32-bit words. The first byte after reset becomes the low byte of a word, and each later byte fills the next byte lane up to the top one. When a word is complete, it is shown on the output with a one-cycle valid strobe. The same word is then compared with two fixed command codes that differ only in their lowest byte. One code asks for a device configuration run. The other code ends the session on the port.

A small controller has three states. **ST_LISTEN** is entered from reset and collects and decodes words. **ST_CONFIG** is entered from ST_LISTEN when the start code arrives, through the transition *start-hit*. In ST_CONFIG the port bytes belong to the configuration engine, so no words are collected. The controller goes back to ST_LISTEN on the transition *cfg-finished*, which is the `cfg_done` input. **ST_RELEASED** is entered from ST_LISTEN when the end code arrives, through the transition *end-hit*. In ST_RELEASED the block gives up the port and ignores every byte until the next reset. A word that matches neither code leaves the controller in ST_LISTEN, through the transition *no-hit*.

Top module: `cmdw_decoder`

## Requirements
- R1: After reset, `port_owned` is 1 and `start_pulse`, `end_pulse` and `word_vld` are 0. The byte lane counter restarts, so the first byte accepted after reset always lands in bits 7:0, even if reset came in the middle of a word.
- R2: A byte is accepted in a cycle where `byte_vld` is 1 at the rising clock edge. Cycles with `byte_vld` at 0 do not advance the lane. Accepted bytes b0, b1, b2, b3 form the word {b3,b2,b1,b0}: b0 goes to bits 7:0, b1 to 15:8, b2 to 23:16 and b3 to 31:24.
- R3: `word_vld` is high for exactly the one cycle after the fourth byte is accepted. During that cycle `word_out` holds the assembled word.
- R4: A word equal to 0xBCBCBCBC raises `start_pulse` in the same cycle as its `word_vld`.
- R5: A word equal to 0xBCBCBC00 raises `end_pulse` in the same cycle as its `word_vld`. From the following cycle, `port_owned` is 0.
- R6: A word that matches neither code still uses all four bytes. It gives `word_vld` but no pulse, and the next word starts at bits 7:0. Near misses such as 0xBCBCBC01 and 0x00BCBCBC count as non-matching.
- R7: After a start code, no bytes are collected and no words are decoded until `cfg_done` is 1 at a clock edge. The next accepted byte after that goes to bits 7:0. `port_owned` stays 1 during this wait.
- R8: Once the port is released, no byte yields `word_vld`, `start_pulse` or `end_pulse`, and `port_owned` stays 0 until reset.
- R9: `start_pulse` and `end_pulse` each last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Incoming port byte |
| byte_vld | input | 1 | `byte_in` carries a byte this cycle |
| cfg_done | input | 1 | Configuration run finished; resume decoding |
| word_out | output | 32 | Last assembled word |
| word_vld | output | 1 | One-cycle strobe: `word_out` is a fresh word |
| start_pulse | output | 1 | One-cycle start-command indication |
| end_pulse | output | 1 | One-cycle end-command indication |
| port_owned | output | 1 | Block holds the port |

## Verification
A lane counter that is out of step shows up as a rotated `word_out` at the next `word_vld`. It can also show up as a strobe one to three bytes early or late, so the check is a comparison of the whole word at the strobe. A controller stuck in the wrong state shows up within one word. In ST_CONFIG it gives a missing `word_vld`. In ST_RELEASED, `port_owned` drops without an end code. If ST_RELEASED fails to take hold, a `word_vld` appears after release. A wrong code comparison shows up as a pulse on a near-miss word, or as a missing pulse on an exact code, in the strobe cycle itself.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;

    typedef enum logic [1:0] {
        ST_LISTEN   = 2'd0,
        ST_CONFIG   = 2'd1,
        ST_RELEASED = 2'd2
    } cmdw_state_e;

endpackage

// File: rtl/cmdw_assembler.sv
module cmdw_assembler #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    output logic [WORD_W-1:0] word_q,
    output logic              done_q
);

    localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(NBYTES - 1);

    logic [CNT_W-1:0] lane_q;

    // Shift right: each new byte enters at the top, so the first byte
    // of a word ends in the lowest lane after NBYTES shifts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                lane_q <= '0;
            end else if (byte_vld) begin
                word_q <= {byte_in, word_q[WORD_W-1:BYTE_W]};
                if (lane_q == LAST_LANE) begin
                    lane_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmdw_matcher.sv
module cmdw_matcher #(
    parameter int WORD_W = 32,
    parameter logic [WORD_W-1:0] CODE = '0
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit
);

    always_comb hit = (word == CODE);

endmodule

// File: rtl/cmdw_fsm.sv
module cmdw_fsm
    import cmdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_done,
    input  logic hit_start,
    input  logic hit_end,
    input  logic cfg_done,
    output logic asm_en,
    output logic start_pulse,
    output logic end_pulse,
    output logic port_owned
);

    cmdw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LISTEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN: begin
                if (word_done && hit_start)    state_d = ST_CONFIG;
                else if (word_done && hit_end) state_d = ST_RELEASED;
            end
            ST_CONFIG: begin
                if (cfg_done) state_d = ST_LISTEN;
            end
            ST_RELEASED: state_d = ST_RELEASED;
            default:     state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        asm_en      = 1'b0;
        start_pulse = 1'b0;
        end_pulse   = 1'b0;
        port_owned  = 1'b1;
        unique case (state_q)
            ST_LISTEN: begin
                start_pulse = word_done && hit_start;
                end_pulse   = word_done && hit_end;
                asm_en      = !(word_done && (hit_start || hit_end));
            end
            ST_CONFIG:   asm_en = 1'b0;
            ST_RELEASED: port_owned = 1'b0;
            default:     asm_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdw_decoder.sv
module cmdw_decoder #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    parameter logic [BYTE_W*NBYTES-1:0] START_CODE = 32'hBCBC_BCBC,
    parameter logic [BYTE_W*NBYTES-1:0] END_CODE   = 32'hBCBC_BC00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BYTE_W-1:0]        byte_in,
    input  logic                     byte_vld,
    input  logic                     cfg_done,
    output logic [BYTE_W*NBYTES-1:0] word_out,
    output logic                     word_vld,
    output logic                     start_pulse,
    output logic                     end_pulse,
    output logic                     port_owned
);

    localparam int WORD_W = BYTE_W * NBYTES;
    localparam int NCODES = 2;
    localparam logic [WORD_W-1:0] CODES [NCODES] = '{START_CODE, END_CODE};

    logic              asm_en;
    logic              done;
    logic [WORD_W-1:0] word;
    logic [NCODES-1:0] hits;

    cmdw_assembler #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (asm_en),
        .byte_in (byte_in),
        .byte_vld(byte_vld),
        .word_q  (word),
        .done_q  (done)
    );

    for (genvar g = 0; g < NCODES; g++) begin : g_match
        cmdw_matcher #(.WORD_W(WORD_W), .CODE(CODES[g])) u_match (
            .word(word),
            .hit (hits[g])
        );
    end

    cmdw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (done),
        .hit_start  (hits[0]),
        .hit_end    (hits[1]),
        .cfg_done   (cfg_done),
        .asm_en     (asm_en),
        .start_pulse(start_pulse),
        .end_pulse  (end_pulse),
        .port_owned (port_owned)
    );

    assign word_out = word;
    assign word_vld = done;

endmodule

// File: rtl/cmdw_checker.sv
module cmdw_checker #(
    parameter int WORD_W = 32,
    parameter logic [WORD_W-1:0] START_CODE = 32'hBCBC_BCBC,
    parameter logic [WORD_W-1:0] END_CODE   = 32'hBCBC_BC00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_out,
    input logic              word_vld,
    input logic              start_pulse,
    input logic              end_pulse,
    input logic              port_owned
);

    // R4
    a_r4_start_matches: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (word_vld && word_out == START_CODE));
    // R5
    a_r5_end_matches: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> (word_vld && word_out == END_CODE));
    a_r5_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !port_owned);
    // R3
    a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R8
    a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !port_owned |=> !port_owned);
    a_r8_silent_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !port_owned |-> !(word_vld || start_pulse || end_pulse));
    // R9
    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !end_pulse);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, end_pulse}));

endmodule

bind cmdw_decoder cmdw_checker #(
    .WORD_W(BYTE_W * NBYTES),
    .START_CODE(START_CODE),
    .END_CODE(END_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_out   (word_out),
    .word_vld   (word_vld),
    .start_pulse(start_pulse),
    .end_pulse  (end_pulse),
    .port_owned (port_owned)
);

// File: tb/cmdw_decoder_tb.sv
module cmdw_decoder_tb;

    localparam logic [31:0] K_START = 32'hBCBC_BCBC;
    localparam logic [31:0] K_END   = 32'hBCBC_BC00;
    localparam int NVEC = 6;
    // {exp_start, exp_end, word}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b00, 32'h1234_5678},
        {2'b00, 32'hBCBC_BC01},
        {2'b00, 32'h00BC_BCBC},
        {2'b10, 32'hBCBC_BCBC},
        {2'b00, 32'hFFFF_FFFF},
        {2'b00, 32'hBCBC_BCBD}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        byte_vld = 1'b0;
    logic        cfg_done = 1'b0;
    logic [31:0] word_out;
    logic        word_vld, start_pulse, end_pulse, port_owned;

    int total = 0;
    int bad = 0;
    int n_vld = 0, n_start = 0, n_end = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmdw_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .cfg_done(cfg_done), .word_out(word_out), .word_vld(word_vld),
        .start_pulse(start_pulse), .end_pulse(end_pulse), .port_owned(port_owned)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (word_vld)    n_vld   <= n_vld + 1;
            if (start_pulse) n_start <= n_start + 1;
            if (end_pulse)   n_end   <= n_end + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drives four bytes low lane first with 'gap' idle cycles between;
    // returns at the negedge of the cycle after the fourth capture.
    task automatic send_word(input logic [31:0] w, input int gap);
        for (int i = 0; i < 4; i++) begin
            byte_in = w[8*i +: 8];
            byte_vld = 1'b1;
            @(negedge clk);
            byte_vld = 1'b0;
            if (i < 3) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic pulse_cfg_done();
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int v0, s0, e0;
        do_reset();
        // R1 reset state
        chk("R1 port_owned", {31'd0, port_owned}, 32'd1);
        chk("R1 word_vld", {31'd0, word_vld}, 32'd0);
        chk("R1 pulses", {30'd0, start_pulse, end_pulse}, 32'd0);

        // Vector walk: R2, R3, R4, R6
        for (int i = 0; i < NVEC; i++) begin
            send_word(VEC[i][31:0], i % 3);
            chk("R3 word_vld", {31'd0, word_vld}, 32'd1);
            chk("R2 word_out", word_out, VEC[i][31:0]);
            chk("R4 start_pulse", {31'd0, start_pulse}, {31'd0, VEC[i][33]});
            chk("R6 end_pulse", {31'd0, end_pulse}, {31'd0, VEC[i][32]});
            @(negedge clk);
            chk("R9 pulses drop", {29'd0, word_vld, start_pulse, end_pulse}, 32'd0);
            chk("R7 port_owned", {31'd0, port_owned}, 32'd1);
            if (VEC[i][33]) pulse_cfg_done();
        end

        // R7: bytes during configuration are not decoded
        send_word(K_START, 0);
        chk("R4 start direct", {31'd0, start_pulse}, 32'd1);
        @(negedge clk);
        v0 = n_vld; e0 = n_end;
        send_word(K_END, 0);
        send_word(32'h0102_0304, 1);
        @(negedge clk);
        chk("R7 no vld in config", n_vld - v0, 0);
        chk("R7 no end in config", n_end - e0, 0);
        chk("R7 owned in config", {31'd0, port_owned}, 32'd1);
        pulse_cfg_done();
        send_word(32'hCAFE_F00D, 2);
        chk("R7 resume aligned", word_out, 32'hCAFE_F00D);
        chk("R7 resume vld", {31'd0, word_vld}, 32'd1);
        @(negedge clk);

        // R1: reset mid-word restores alignment
        byte_in = 8'hAA; byte_vld = 1'b1; @(negedge clk);
        byte_in = 8'hBB; @(negedge clk);
        byte_vld = 1'b0;
        do_reset();
        send_word(32'h5566_7788, 0);
        chk("R1 realign after reset", word_out, 32'h5566_7788);
        @(negedge clk);

        // R5: end code releases the port
        send_word(K_END, 1);
        chk("R5 end_pulse", {31'd0, end_pulse}, 32'd1);
        chk("R5 end word", word_out, K_END);
        chk("R5 start quiet", {31'd0, start_pulse}, 32'd0);
        @(negedge clk);
        chk("R5 released", {31'd0, port_owned}, 32'd0);
        chk("R9 end single", {31'd0, end_pulse}, 32'd0);

        // R8: nothing decoded after release
        v0 = n_vld; s0 = n_start; e0 = n_end;
        send_word(K_START, 0);
        send_word(K_END, 0);
        send_word(32'h1111_2222, 0);
        @(negedge clk);
        chk("R8 no vld", n_vld - v0, 0);
        chk("R8 no start", n_start - s0, 0);
        chk("R8 no end", n_end - e0, 0);
        chk("R8 still released", {31'd0, port_owned}, 32'd0);

        // R1: reset reclaims the port and decoding works again
        do_reset();
        chk("R1 reclaimed", {31'd0, port_owned}, 32'd1);
        send_word(K_START, 0);
        chk("R4 start after reset", {31'd0, start_pulse}, 32'd1);
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000 * 1ns);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule